// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit compares two IEEE-754 operands and writes a single condition flag. An 8-bit operation code picks the precision and the predicate. Single precision uses the low 32 bits of each operand. Double precision uses all 64 bits.

There are three families of predicate, and each exists at both precisions:

- **Ordered compares:** equal, not-equal, greater, greater-or-equal, less and less-or-equal.
- **Unordered-or compares:** the same six predicates, ORed with a NaN test.
- **Pure unordered test:** true when either operand is NaN.

A compare never produces a data result. It only updates the flag and pulses a flag-write enable. An opcode outside the compare space does not change the flag and pulses an illegal-opcode indication instead.

NaN detection, equality of signed zeros and sign-magnitude ordering are handled inside the unit. One opcode is accepted per valid strobe, and its outcome appears one clock later.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While reset is asserted and after its release with no strobe, `flag_o`, `flag_we_o` and `illegal_o` are 0.
- R2: The opcode fields are decoded as follows:
  - Bits 7:6 must be 00 and bit 3 must be 1.
  - Bit 4 selects double precision.
  - Bit 5 selects the unordered-or family.
  - Bits 2:0 pick the predicate: 0 eq, 1 ne, 2 gt, 3 ge, 4 lt, 5 le.
  - Value 6 in bits 2:0 is the pure unordered test and is legal only with bit 5 set.
  - The legal codes are therefore 0x08-0x0D, 0x18-0x1D, 0x28-0x2E and 0x38-0x3E.
- R3: For non-NaN operands, a legal ordered code sets `flag_o` to the predicate result and pulses `flag_we_o` high for exactly one cycle. Both happen on the clock edge after the strobe.
- R4: NaN means an all-ones exponent with a nonzero fraction; an infinity is not a NaN. With a NaN operand, every ordered predicate gives 0, except ne, which gives 1.
- R5: An unordered-or code gives the OR of "either operand is NaN" and its ordered predicate.
- R6: The pure unordered code (0x2E single, 0x3E double) gives 1 exactly when at least one operand is NaN.
- R7: +0 and -0 compare equal, and neither is less than or greater than the other.
- R8: Double-precision codes order and detect NaN over all 64 bits. Single-precision codes ignore bits 63:32 of both operands.
- R9: An illegal opcode with a strobe leaves `flag_o` unchanged, pulses `illegal_o` for one cycle and keeps `flag_we_o` low.
- R10: A cycle with no strobe holds `flag_o` and drives both pulses low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Strobe: an opcode and its operands are present |
| op_code_i | input | 8 | Compare opcode |
| opa_i | input | 64 | Operand A (single precision in bits 31:0) |
| opb_i | input | 64 | Operand B (single precision in bits 31:0) |
| flag_o | output | 1 | Registered condition flag |
| flag_we_o | output | 1 | One-cycle pulse: flag written |
| illegal_o | output | 1 | One-cycle pulse: opcode rejected |

## Verification
The flag is the unit's only state, so most faults are visible on the cycle after the strobe that exposes them. A wrong predicate, a mis-detected NaN, or a zero or sign ordering slip shows there as a wrong `flag_o`. A flag overwritten by an illegal or idle cycle appears as a changed flag with no write pulse. The bench sweeps every predicate over ordered pairs, signed zeros, infinities and NaNs at both precisions, and follows each rejected code with an idle cycle so that any corruption of the held flag is observed.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int OP_W   = 8;
  localparam int SP_EXP = 8;
  localparam int SP_MAN = 23;
  localparam int DP_EXP = 11;
  localparam int DP_MAN = 52;
  localparam int SP_W   = SP_EXP + SP_MAN + 1;
  localparam int DP_W   = DP_EXP + DP_MAN + 1;

  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_NE    = 3'd1,
    PRED_GT    = 3'd2,
    PRED_GE    = 3'd3,
    PRED_LT    = 3'd4,
    PRED_LE    = 3'd5,
    PRED_UNORD = 3'd6,
    PRED_RSVD  = 3'd7
  } pred_e;

  typedef struct packed {
    logic  legal;
    logic  dbl;
    logic  unord_or;
    pred_e pred;
  } dec_t;

  typedef struct packed {
    logic unord;
    logic eq;
    logic lt;
    logic gt;
  } rel_t;
endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
(
  input  logic [OP_W-1:0] op_code_i,
  output dec_t            dec_o
);
  logic  space_ok;
  logic  pred_ok;
  pred_e pred;

  always_comb begin
    pred     = pred_e'(op_code_i[2:0]);
    space_ok = (op_code_i[7:6] == 2'b00) && op_code_i[3];
    pred_ok  = (op_code_i[2:0] <= 3'd5) ||
               ((pred == PRED_UNORD) && op_code_i[5]);
    dec_o.legal    = space_ok && pred_ok;
    dec_o.dbl      = op_code_i[4];
    dec_o.unord_or = op_code_i[5];
    dec_o.pred     = pred;
  end
endmodule

// File: rtl/fcmp_core.sv
module fcmp_core
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  output rel_t                 rel_o
);
  localparam int W   = EXP_W + MAN_W + 1;
  localparam int MAG = W - 1;

  logic           sign_a, sign_b;
  logic [MAG-1:0] mag_a, mag_b;
  logic           nan_a, nan_b, both_zero, mag_lt, mag_eq;
  logic           eq_raw, lt_raw, gt_raw, unord;

  always_comb begin
    sign_a    = a_i[W-1];
    sign_b    = b_i[W-1];
    mag_a     = a_i[MAG-1:0];
    mag_b     = b_i[MAG-1:0];
    nan_a     = (&mag_a[MAG-1:MAN_W]) && (|mag_a[MAN_W-1:0]);
    nan_b     = (&mag_b[MAG-1:MAN_W]) && (|mag_b[MAN_W-1:0]);
    unord     = nan_a || nan_b;
    both_zero = ~(|mag_a) && ~(|mag_b);
    mag_lt    = mag_a < mag_b;
    mag_eq    = mag_a == mag_b;
    eq_raw    = both_zero || ((sign_a == sign_b) && mag_eq);
    if (both_zero)             lt_raw = 1'b0;
    else if (sign_a != sign_b) lt_raw = sign_a;
    else if (sign_a)           lt_raw = !mag_lt && !mag_eq;
    else                       lt_raw = mag_lt;
    gt_raw    = !eq_raw && !lt_raw;
    rel_o.unord = unord;
    rel_o.eq    = eq_raw && !unord;
    rel_o.lt    = lt_raw && !unord;
    rel_o.gt    = gt_raw && !unord;
  end
endmodule

// File: rtl/fcmp_eval.sv
module fcmp_eval
  import fcmp_pkg::*;
(
  input  dec_t dec_i,
  input  rel_t sp_rel_i,
  input  rel_t dp_rel_i,
  output logic result_o
);
  rel_t rel;
  logic ord_hit;

  always_comb begin
    rel = dec_i.dbl ? dp_rel_i : sp_rel_i;
    unique case (dec_i.pred)
      PRED_EQ: ord_hit = rel.eq;
      PRED_NE: ord_hit = !rel.eq;
      PRED_GT: ord_hit = rel.gt;
      PRED_GE: ord_hit = rel.gt || rel.eq;
      PRED_LT: ord_hit = rel.lt;
      PRED_LE: ord_hit = rel.lt || rel.eq;
      default: ord_hit = 1'b0;
    endcase
    result_o = ord_hit || (dec_i.unord_or && rel.unord);
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_code_i,
  input  logic [DP_W-1:0] opa_i,
  input  logic [DP_W-1:0] opb_i,
  output logic            flag_o,
  output logic            flag_we_o,
  output logic            illegal_o
);
  dec_t dec;
  rel_t sp_rel, dp_rel;
  logic result;
  logic flag_d, we_d, ill_d;
  logic flag_q, we_q, ill_q;
  logic accept;

  fcmp_decode u_dec (.op_code_i(op_code_i), .dec_o(dec));

  fcmp_core #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
    .a_i(opa_i[SP_W-1:0]), .b_i(opb_i[SP_W-1:0]), .rel_o(sp_rel));

  fcmp_core #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
    .a_i(opa_i), .b_i(opb_i), .rel_o(dp_rel));

  fcmp_eval u_eval (
    .dec_i(dec), .sp_rel_i(sp_rel), .dp_rel_i(dp_rel), .result_o(result));

  always_comb begin
    accept = op_valid_i && dec.legal;
    flag_d = accept ? result : flag_q;
    we_d   = accept;
    ill_d  = op_valid_i && !dec.legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      we_q   <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      we_q   <= we_d;
      ill_q  <= ill_d;
    end
  end

  assign flag_o    = flag_q;
  assign flag_we_o = we_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/fcmp_flag_unit_chk.sv
module fcmp_flag_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid_i,
  input logic [7:0]  op_code_i,
  input logic [31:0] opa_lo,
  input logic [31:0] opb_lo,
  input logic        flag_o,
  input logic        flag_we_o,
  input logic        illegal_o
);
  logic sp_a_nan, sp_a_zero, sp_b_zero;
  assign sp_a_nan  = (opa_lo[30:23] == 8'hFF) && (opa_lo[22:0] != 23'd0);
  assign sp_a_zero = opa_lo[30:0] == 31'd0;
  assign sp_b_zero = opb_lo[30:0] == 31'd0;

  p_we_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> $past(op_valid_i));

  p_illegal_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(op_valid_i));

  p_we_illegal_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_we_o && illegal_o));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we_o |-> $stable(flag_o));

  p_unord_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_code_i == 8'h2E && sp_a_nan) |=> (flag_o && flag_we_o));

  p_zero_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_code_i == 8'h08 && sp_a_zero && sp_b_zero) |=> flag_o);
endmodule

bind fcmp_flag_unit fcmp_flag_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
  .opa_lo(opa_i[31:0]), .opb_lo(opb_i[31:0]), .flag_o(flag_o),
  .flag_we_o(flag_we_o), .illegal_o(illegal_o));

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid_i;
  logic [7:0]  op_code_i;
  logic [63:0] opa_i, opb_i;
  logic        flag_o, flag_we_o, illegal_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit model_flag = 0;

  logic [2:0] exp_q[$];
  string      tag_q[$];

  localparam logic [31:0] S_ONE = 32'h3F800000, S_TWO = 32'h40000000;
  localparam logic [31:0] S_M1  = 32'hBF800000, S_M2  = 32'hC0000000;
  localparam logic [31:0] S_INF = 32'h7F800000, S_NAN = 32'h7FC00000;
  localparam logic [31:0] S_PZ  = 32'h00000000, S_NZ  = 32'h80000000;
  localparam logic [63:0] D_ONE = 64'h3FF0000000000000, D_TWO = 64'h4000000000000000;
  localparam logic [63:0] D_M1  = 64'hBFF0000000000000, D_NAN = 64'h7FF8000000000001;
  localparam logic [63:0] D_NZ  = 64'h8000000000000000;

  always #10 clk = ~clk;

  fcmp_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .opa_i(opa_i), .opb_i(opb_i), .flag_o(flag_o), .flag_we_o(flag_we_o),
    .illegal_o(illegal_o));

  function automatic bit m_nan(bit dbl, logic [63:0] x);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 52'd0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  function automatic logic [63:0] m_key(bit dbl, logic [63:0] x);
    logic [63:0] v, top;
    v   = dbl ? x : {32'd0, x[31:0]};
    top = dbl ? 64'h8000000000000000 : 64'h0000000080000000;
    if ((v & ~top) == 64'd0) return top;
    if ((v & top) != 64'd0) return dbl ? ~v : {32'd0, ~v[31:0]};
    return v | top;
  endfunction

  function automatic bit m_legal(logic [7:0] op);
    return (op >= 8'h08 && op <= 8'h0D) || (op >= 8'h18 && op <= 8'h1D) ||
           (op >= 8'h28 && op <= 8'h2E) || (op >= 8'h38 && op <= 8'h3E);
  endfunction

  function automatic bit m_eval(logic [7:0] op, logic [63:0] a, logic [63:0] b);
    bit dbl, un, r;
    logic [63:0] ka, kb;
    dbl = op[4];
    un  = m_nan(dbl, a) || m_nan(dbl, b);
    ka  = m_key(dbl, a);
    kb  = m_key(dbl, b);
    case (op[2:0])
      3'd0: r = !un && ka == kb;
      3'd1: r = un || ka != kb;
      3'd2: r = !un && ka > kb;
      3'd3: r = !un && ka >= kb;
      3'd4: r = !un && ka < kb;
      3'd5: r = !un && ka <= kb;
      default: r = 0;
    endcase
    if (op[5]) r = r || un;
    return r;
  endfunction

  task automatic drive(bit v, logic [7:0] op, logic [63:0] a, logic [63:0] b, string tag);
    bit lg;
    @(negedge clk);
    op_valid_i = v; op_code_i = op; opa_i = a; opb_i = b;
    lg = m_legal(op);
    if (v && lg) model_flag = m_eval(op, a, b);
    exp_q.push_back({model_flag, v && lg, v && !lg});
    tag_q.push_back(tag);
  endtask

  task automatic idle(string tag);
    drive(1'b0, 8'h00, 64'd0, 64'd0, tag);
  endtask

  task automatic sp_all(logic [7:0] base, logic [31:0] a, logic [31:0] b, string tag);
    for (int p = 0; p < 6; p++) drive(1'b1, base + 8'(p), {32'd0, a}, {32'd0, b}, tag);
  endtask

  task automatic dp_all(logic [7:0] base, logic [63:0] a, logic [63:0] b, string tag);
    for (int p = 0; p < 6; p++) drive(1'b1, base + 8'(p), a, b, tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk); #5;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({flag_o, flag_we_o, illegal_o} !== e) begin
          n_fail++;
          $display("FAIL %s: {flag,we,illegal} actual %b expected %b", t,
                   {flag_o, flag_we_o, illegal_o}, e);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_valid_i = 0; op_code_i = 0; opa_i = 0; opb_i = 0;
    repeat (3) @(posedge clk);
    #5;
    n_tests++;
    if ({flag_o, flag_we_o, illegal_o} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1: actual %b expected 000", {flag_o, flag_we_o, illegal_o});
    end
    @(negedge clk); rst_n = 1;
    idle("R1 idle after reset");
    idle("R10 idle");
    // R3: ordered single compares, R2 encodings 0x08-0x0D
    sp_all(8'h08, S_ONE, S_TWO, "R3 1<2");
    sp_all(8'h08, S_TWO, S_ONE, "R3 2>1");
    sp_all(8'h08, S_ONE, S_ONE, "R3 1==1");
    sp_all(8'h08, S_M1, S_ONE, "R3 -1<1");
    sp_all(8'h08, S_M2, S_M1, "R3 -2<-1");
    sp_all(8'h08, S_INF, S_TWO, "R4 inf not NaN");
    // R7 signed zero
    sp_all(8'h08, S_NZ, S_PZ, "R7 -0 vs +0");
    sp_all(8'h08, S_PZ, S_NZ, "R7 +0 vs -0");
    // R4 NaN in ordered compares
    sp_all(8'h08, S_NAN, S_ONE, "R4 NaN a");
    sp_all(8'h08, S_ONE, S_NAN, "R4 NaN b");
    // R5 unordered-or
    sp_all(8'h28, S_NAN, S_ONE, "R5 NaN");
    sp_all(8'h28, S_ONE, S_TWO, "R5 ordered");
    // R6 pure unordered
    drive(1'b1, 8'h2E, {32'd0, S_NAN}, {32'd0, S_ONE}, "R6 NaN a");
    drive(1'b1, 8'h2E, {32'd0, S_ONE}, {32'd0, S_NAN}, "R6 NaN b");
    drive(1'b1, 8'h2E, {32'd0, S_INF}, {32'd0, S_INF}, "R6 inf,inf");
    drive(1'b1, 8'h3E, D_NAN, D_ONE, "R6 double NaN");
    drive(1'b1, 8'h3E, D_ONE, D_TWO, "R6 double ordered");
    // R8 double precision and single ignoring upper bits
    dp_all(8'h18, D_ONE, D_TWO, "R8 d 1<2");
    dp_all(8'h18, D_M1, D_ONE, "R8 d -1<1");
    dp_all(8'h18, D_NZ, 64'd0, "R8 d -0==+0");
    dp_all(8'h18, D_NAN, D_ONE, "R8 d NaN");
    dp_all(8'h38, D_NAN, D_TWO, "R8 d unordered-or");
    drive(1'b1, 8'h0C, {32'hFFFFFFFF, S_ONE}, {32'h00000001, S_TWO}, "R8 sp upper ignored");
    drive(1'b1, 8'h08, {32'h7FF80000, S_ONE}, {32'h12345678, S_ONE}, "R8 sp upper NaN ignored");
    drive(1'b1, 8'h18, {32'd0, 32'd1}, {32'd0, 32'd2}, "R8 d low-word only");
    // R9 illegal codes, each followed by an idle cycle to observe the held flag
    drive(1'b1, 8'h08, {32'd0, S_ONE}, {32'd0, S_ONE}, "R3 set flag");
    begin
      logic [7:0] bad [8] = '{8'h0E, 8'h0F, 8'h1E, 8'h2F, 8'h3F, 8'h48, 8'h00, 8'h8C};
      for (int i = 0; i < 8; i++) begin
        drive(1'b1, bad[i], {32'd0, S_ONE}, {32'd0, S_TWO}, "R9 illegal");
        idle("R10 flag held after illegal");
      end
    end
    drive(1'b1, 8'h0B, {32'd0, S_ONE}, {32'd0, S_TWO}, "R2 ge clears flag");
    drive(1'b1, 8'h4B, {32'd0, S_TWO}, {32'd0, S_ONE}, "R2 bit6 illegal");
    idle("R10 hold");
    idle("R10 hold");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule